// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block turns a raw window of fetched bytes into the fields of one instruction. It receives six consecutive bytes that begin at the current program counter, along with the counter value itself. Byte 0 alone sets the instruction class, the function code and the encoded length, which is 1, 2, 5 or 6 bytes. The block then pulls out the two register specifiers and any 32-bit constant. It also produces the address of the next sequential instruction.

The block is purely combinational. It sits between instruction memory and the execute stage. The fetch stage supplies the byte window, and the downstream stages consume the decoded fields, the halt flag and the invalid-instruction flag. The register specifier value 0xF means that no register is named.

Top module: `instr_field_decoder`

## Requirements
- R1: The class output is the high nibble of byte 0 and the function output is its low nibble. The class codes are 0 no-op, 1 halt, 2 register copy, 3 load immediate, 4 store to memory, 5 load from memory, 6 arithmetic/logic, 7 conditional jump, 8 call, 9 return, A push and B pop.
- R2: The length output is 1 for no-op, halt and return. It is 2 for register copy, arithmetic/logic, push and pop. It is 5 for jump and call. It is 6 for load immediate, store and load.
- R3: For classes 2, 3, 4, 5, 6, A and B, the first register output is the high nibble of byte 1 and the second register output is its low nibble.
- R4: For classes without a register byte (0, 1, 7, 8 and 9), both register outputs are 0xF. This holds whatever the trailing bytes contain.
- R5: For classes 3, 4 and 5, the constant output is bytes 2 to 5 read little-endian, with byte 2 as the least significant byte.
- R6: For classes 7 and 8, the constant output is the absolute destination held in bytes 1 to 4, read little-endian.
- R7: For every class without a constant, the constant output is zero, even when the trailing bytes are nonzero.
- R8: The next-address output equals the program counter plus the length output, with 32-bit wraparound.
- R9: The halt flag is 1 exactly when the class code is 1.
- R10: The invalid flag is raised in three cases: a class code above B; a nonzero function code in any class other than 6 or 7; a function code above 3 in class 6 or above 6 in class 7. When it is raised, the length is 1, both register outputs are 0xF and the constant is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of byte 0 |
| fetch_bytes_i | input | 48 | Six fetched bytes; byte k occupies bits 8k+7..8k |
| icode_o | output | 4 | Instruction class code |
| ifun_o | output | 4 | Function code |
| len_o | output | 3 | Decoded instruction length in bytes |
| ra_o | output | 4 | First register specifier, 0xF if none |
| rb_o | output | 4 | Second register specifier, 0xF if none |
| const_o | output | 32 | Immediate, displacement or destination; zero if none |
| next_pc_o | output | 32 | Address of the next sequential instruction |
| halt_o | output | 1 | Halt instruction decoded |
| bad_o | output | 1 | Invalid class or function code |

## Verification
The bench targets the fact that the constant sits at two different offsets. A decoder that read it from a fixed offset would return a value shifted by one byte for either the jump/call group or the move group. Trailing bytes are loaded with nonzero garbage for short instructions. A design that did not gate register and constant extraction by class would leak that garbage onto the register and constant outputs. Boundary function codes are tested: 3 and 4 for arithmetic, 6 and 7 for jumps, and a nonzero function on halt. So is a program counter near the top of the address space. An off-by-one validity limit would flip the invalid flag, and a narrow adder would give a wrong wrapped next address.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

    localparam int BYTE_W      = 8;
    localparam int FETCH_BYTES = 6;
    localparam int FETCH_W     = BYTE_W * FETCH_BYTES;
    localparam int TAIL_W      = BYTE_W * (FETCH_BYTES - 1);
    localparam int WORD_W      = 32;
    localparam int NIB_W       = 4;
    localparam int LEN_W       = 3;

    localparam logic [NIB_W-1:0] NO_REG = 4'hF;

    localparam logic [NIB_W-1:0] IC_NOP   = 4'h0;
    localparam logic [NIB_W-1:0] IC_HALT  = 4'h1;
    localparam logic [NIB_W-1:0] IC_MOVRR = 4'h2;
    localparam logic [NIB_W-1:0] IC_MOVIR = 4'h3;
    localparam logic [NIB_W-1:0] IC_MOVRM = 4'h4;
    localparam logic [NIB_W-1:0] IC_MOVMR = 4'h5;
    localparam logic [NIB_W-1:0] IC_ALU   = 4'h6;
    localparam logic [NIB_W-1:0] IC_JXX   = 4'h7;
    localparam logic [NIB_W-1:0] IC_CALL  = 4'h8;
    localparam logic [NIB_W-1:0] IC_RET   = 4'h9;
    localparam logic [NIB_W-1:0] IC_PUSH  = 4'hA;
    localparam logic [NIB_W-1:0] IC_POP   = 4'hB;

    localparam logic [NIB_W-1:0] ALU_FN_MAX = 4'h3;
    localparam logic [NIB_W-1:0] JXX_FN_MAX = 4'h6;

    // Where the 32-bit constant starts inside the fetched window
    typedef enum logic [1:0] {
        CPOS_NONE  = 2'd0,
        CPOS_BYTE1 = 2'd1,
        CPOS_BYTE2 = 2'd2
    } const_pos_e;

    typedef struct packed {
        logic             has_reg;
        const_pos_e       cpos;
        logic [LEN_W-1:0] len;
        logic             halt;
        logic             bad;
    } ctl_t;

    function automatic logic fn_valid(logic [NIB_W-1:0] ic, logic [NIB_W-1:0] fn);
        case (ic)
            IC_ALU:  return fn <= ALU_FN_MAX;
            IC_JXX:  return fn <= JXX_FN_MAX;
            default: return fn == '0;
        endcase
    endfunction

    function automatic ctl_t class_ctl(logic [NIB_W-1:0] ic);
        ctl_t c;
        c = '{has_reg: 1'b0, cpos: CPOS_NONE, len: LEN_W'(1), halt: 1'b0, bad: 1'b0};
        case (ic)
            IC_MOVRR, IC_ALU, IC_PUSH, IC_POP: begin
                c.has_reg = 1'b1;
                c.len     = LEN_W'(2);
            end
            IC_MOVIR, IC_MOVRM, IC_MOVMR: begin
                c.has_reg = 1'b1;
                c.cpos    = CPOS_BYTE2;
                c.len     = LEN_W'(6);
            end
            IC_JXX, IC_CALL: begin
                c.cpos = CPOS_BYTE1;
                c.len  = LEN_W'(5);
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ifd_class_decode.sv
module ifd_class_decode
    import ifd_pkg::*;
(
    input  logic [BYTE_W-1:0] byte0_i,
    output logic [NIB_W-1:0]  icode_o,
    output logic [NIB_W-1:0]  ifun_o,
    output ctl_t              ctl_o
);

    logic [NIB_W-1:0] ic;
    logic [NIB_W-1:0] fn;
    logic             known;
    ctl_t             base;

    assign ic      = byte0_i[BYTE_W-1:NIB_W];
    assign fn      = byte0_i[NIB_W-1:0];
    assign icode_o = ic;
    assign ifun_o  = fn;
    assign known   = (ic <= IC_POP);

    always_comb begin
        base        = class_ctl(ic);
        ctl_o       = base;
        ctl_o.halt  = (ic == IC_HALT);
        ctl_o.bad   = !known || !fn_valid(ic, fn);
        if (ctl_o.bad) begin
            ctl_o.has_reg = 1'b0;
            ctl_o.cpos    = CPOS_NONE;
            ctl_o.len     = LEN_W'(1);
        end
    end

    always_comb begin
        // R2
        len_legal_chk: assert (ctl_o.len == 3'd1 || ctl_o.len == 3'd2 ||
                               ctl_o.len == 3'd5 || ctl_o.len == 3'd6);
    end

endmodule

// File: rtl/ifd_field_extract.sv
module ifd_field_extract
    import ifd_pkg::*;
(
    input  logic [TAIL_W-1:0] tail_i,
    input  ctl_t              ctl_i,
    output logic [NIB_W-1:0]  ra_o,
    output logic [NIB_W-1:0]  rb_o,
    output logic [WORD_W-1:0] const_o
);

    localparam int AT1_LO = 0;
    localparam int AT2_LO = BYTE_W;

    logic [BYTE_W-1:0] reg_byte;
    logic [WORD_W-1:0] word_at1;
    logic [WORD_W-1:0] word_at2;

    assign reg_byte = tail_i[BYTE_W-1:0];
    assign word_at1 = tail_i[AT1_LO +: WORD_W];
    assign word_at2 = tail_i[AT2_LO +: WORD_W];

    always_comb begin
        if (ctl_i.has_reg) begin
            ra_o = reg_byte[BYTE_W-1:NIB_W];
            rb_o = reg_byte[NIB_W-1:0];
        end else begin
            ra_o = NO_REG;
            rb_o = NO_REG;
        end
        case (ctl_i.cpos)
            CPOS_BYTE1: const_o = word_at1;
            CPOS_BYTE2: const_o = word_at2;
            default:    const_o = '0;
        endcase
    end

endmodule

// File: rtl/ifd_next_pc.sv
module ifd_next_pc
    import ifd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] next_pc_o
);

    localparam int PAD_W = ADDR_W - LEN_W;

    assign next_pc_o = pc_i + {{PAD_W{1'b0}}, len_i};

endmodule

// File: rtl/instr_field_decoder.sv
module instr_field_decoder
    import ifd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]  pc_i,
    input  logic [FETCH_W-1:0] fetch_bytes_i,
    output logic [NIB_W-1:0]   icode_o,
    output logic [NIB_W-1:0]   ifun_o,
    output logic [LEN_W-1:0]   len_o,
    output logic [NIB_W-1:0]   ra_o,
    output logic [NIB_W-1:0]   rb_o,
    output logic [WORD_W-1:0]  const_o,
    output logic [ADDR_W-1:0]  next_pc_o,
    output logic               halt_o,
    output logic               bad_o
);

    ctl_t ctl;

    ifd_class_decode u_class (
        .byte0_i (fetch_bytes_i[BYTE_W-1:0]),
        .icode_o (icode_o),
        .ifun_o  (ifun_o),
        .ctl_o   (ctl)
    );

    ifd_field_extract u_extract (
        .tail_i  (fetch_bytes_i[FETCH_W-1:BYTE_W]),
        .ctl_i   (ctl),
        .ra_o    (ra_o),
        .rb_o    (rb_o),
        .const_o (const_o)
    );

    ifd_next_pc #(.ADDR_W(ADDR_W)) u_npc (
        .pc_i      (pc_i),
        .len_i     (ctl.len),
        .next_pc_o (next_pc_o)
    );

    assign len_o  = ctl.len;
    assign halt_o = ctl.halt;
    assign bad_o  = ctl.bad;

    always_comb begin
        // R8
        npc_step_chk: assert ((next_pc_o - pc_i) == ADDR_W'(len_o));
        if (halt_o) begin
            // R9
            halt_code_chk: assert (icode_o == IC_HALT);
        end
        if (bad_o) begin
            // R10
            bad_fields_chk: assert (len_o == 3'd1 && ra_o == NO_REG &&
                                    rb_o == NO_REG && const_o == '0);
        end
        if (len_o == 3'd1 || len_o == 3'd5) begin
            // R4
            noreg_chk: assert (ra_o == NO_REG && rb_o == NO_REG);
        end
        if (len_o < 3'd5) begin
            // R7
            noconst_chk: assert (const_o == '0);
        end
    end

endmodule

// File: tb/test_instr_field_decoder.sv
module test_instr_field_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [31:0] pc;
    logic [47:0] fb;
    logic [3:0]  icode, ifun, ra, rb;
    logic [2:0]  len;
    logic [31:0] cval, npc;
    logic        halt, bad;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    instr_field_decoder i_instr_field_decoder (
        .pc_i          (pc),
        .fetch_bytes_i (fb),
        .icode_o       (icode),
        .ifun_o        (ifun),
        .len_o         (len),
        .ra_o          (ra),
        .rb_o          (rb),
        .const_o       (cval),
        .next_pc_o     (npc),
        .halt_o        (halt),
        .bad_o         (bad)
    );

    function automatic logic [47:0] pack(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] p, input logic [47:0] bytes);
        @(negedge clk);
        pc = p;
        fb = bytes;
        #1;
    endtask

    task automatic expect_all(input string tag, input logic [3:0] e_ic, e_fn, input logic [2:0] e_len,
                              input logic [3:0] e_ra, e_rb, input logic [31:0] e_c, e_npc,
                              input logic e_halt, e_bad);
        chk(tag, "icode", 32'(icode), 32'(e_ic));
        chk(tag, "ifun",  32'(ifun),  32'(e_fn));
        chk(tag, "len",   32'(len),   32'(e_len));
        chk(tag, "ra",    32'(ra),    32'(e_ra));
        chk(tag, "rb",    32'(rb),    32'(e_rb));
        chk(tag, "const", cval,       e_c);
        chk(tag, "next_pc", npc,      e_npc);
        chk(tag, "halt",  32'(halt),  32'(e_halt));
        chk(tag, "bad",   32'(bad),   32'(e_bad));
    endtask

    // R1 R2 R4 R7: all-zero window decodes as a one-byte no-op
    task automatic t_idle;
        apply(32'h0, '0);
        expect_all("R1/R2/R4/R7 nop", 4'h0, 4'h0, 3'd1, 4'hF, 4'hF, 32'h0, 32'h1, 1'b0, 1'b0);
    endtask

    // R3 R5: load immediate, constant at bytes 2..5
    task automatic t_load_imm;
        apply(32'h100, pack(8'h30, 8'h82, 8'hcd, 8'hab, 8'h00, 8'h00));
        expect_all("R3/R5 load-imm", 4'h3, 4'h0, 3'd6, 4'h8, 4'h2, 32'h0000abcd, 32'h106, 1'b0, 1'b0);
    endtask

    // R5: load from memory with negative displacement, store with positive
    task automatic t_mem_moves;
        apply(32'h20, pack(8'h50, 8'h15, 8'hf4, 8'hff, 8'hff, 8'hff));
        expect_all("R5 load", 4'h5, 4'h0, 3'd6, 4'h1, 4'h5, 32'hfffffff4, 32'h26, 1'b0, 1'b0);
        apply(32'h40, pack(8'h40, 8'h64, 8'h1c, 8'h04, 8'h00, 8'h00));
        expect_all("R5 store", 4'h4, 4'h0, 3'd6, 4'h6, 4'h4, 32'h0000041c, 32'h46, 1'b0, 1'b0);
    endtask

    // R6 R4: jump and call take destination from bytes 1..4, byte 5 ignored
    task automatic t_branches;
        apply(32'h200, pack(8'h74, 8'h78, 8'h56, 8'h34, 8'h12, 8'hee));
        expect_all("R6 jump", 4'h7, 4'h4, 3'd5, 4'hF, 4'hF, 32'h12345678, 32'h205, 1'b0, 1'b0);
        apply(32'h300, pack(8'h80, 8'h28, 8'h00, 8'h00, 8'h00, 8'h99));
        expect_all("R6 call", 4'h8, 4'h0, 3'd5, 4'hF, 4'hF, 32'h00000028, 32'h305, 1'b0, 1'b0);
        apply(32'h310, pack(8'h76, 8'hef, 8'hbe, 8'had, 8'hde, 8'h11));
        expect_all("R6 jump fn6", 4'h7, 4'h6, 3'd5, 4'hF, 4'hF, 32'hdeadbeef, 32'h315, 1'b0, 1'b0);
    endtask

    // R3 R7: two-byte classes with garbage trailing bytes
    task automatic t_two_byte;
        apply(32'h10, pack(8'h63, 8'hab, 8'h11, 8'h22, 8'h33, 8'h44));
        expect_all("R3/R7 alu", 4'h6, 4'h3, 3'd2, 4'hA, 4'hB, 32'h0, 32'h12, 1'b0, 1'b0);
        apply(32'h14, pack(8'ha0, 8'h2f, 8'hff, 8'hff, 8'hff, 8'hff));
        expect_all("R3/R7 push", 4'hA, 4'h0, 3'd2, 4'h2, 4'hF, 32'h0, 32'h16, 1'b0, 1'b0);
        apply(32'h16, pack(8'hb0, 8'h5f, 8'h77, 8'h77, 8'h77, 8'h77));
        expect_all("R3/R7 pop", 4'hB, 4'h0, 3'd2, 4'h5, 4'hF, 32'h0, 32'h18, 1'b0, 1'b0);
        apply(32'h18, pack(8'h20, 8'h43, 8'h55, 8'h55, 8'h55, 8'h55));
        expect_all("R3/R7 copy", 4'h2, 4'h0, 3'd2, 4'h4, 4'h3, 32'h0, 32'h1a, 1'b0, 1'b0);
    endtask

    // R4 R7 R9: one-byte classes ignore trailing bytes
    task automatic t_one_byte;
        apply(32'h50, pack(8'h90, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9a));
        expect_all("R4/R7 return", 4'h9, 4'h0, 3'd1, 4'hF, 4'hF, 32'h0, 32'h51, 1'b0, 1'b0);
        apply(32'h60, pack(8'h10, 8'h88, 8'h88, 8'h88, 8'h88, 8'h88));
        expect_all("R9 halt", 4'h1, 4'h0, 3'd1, 4'hF, 4'hF, 32'h0, 32'h61, 1'b1, 1'b0);
    endtask

    // R8: next address wraps at 32 bits
    task automatic t_wrap;
        apply(32'hffff_fffe, pack(8'h30, 8'hf1, 8'h01, 8'h00, 8'h00, 8'h00));
        expect_all("R8 wrap", 4'h3, 4'h0, 3'd6, 4'hF, 4'h1, 32'h1, 32'h4, 1'b0, 1'b0);
    endtask

    // R10: invalid codes collapse to length 1 with empty fields
    task automatic t_invalid;
        apply(32'h80, pack(8'hc0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9a));
        expect_all("R10 class C", 4'hC, 4'h0, 3'd1, 4'hF, 4'hF, 32'h0, 32'h81, 1'b0, 1'b1);
        apply(32'h90, pack(8'h64, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9a));
        expect_all("R10 alu fn4", 4'h6, 4'h4, 3'd1, 4'hF, 4'hF, 32'h0, 32'h91, 1'b0, 1'b1);
        apply(32'ha0, pack(8'h77, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9a));
        expect_all("R10 jump fn7", 4'h7, 4'h7, 3'd1, 4'hF, 4'hF, 32'h0, 32'ha1, 1'b0, 1'b1);
        apply(32'hb0, pack(8'h21, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9a));
        expect_all("R10 copy fn1", 4'h2, 4'h1, 3'd1, 4'hF, 4'hF, 32'h0, 32'hb1, 1'b0, 1'b1);
        apply(32'hc0, pack(8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00));
        expect_all("R9/R10 halt fn1", 4'h1, 4'h1, 3'd1, 4'hF, 4'hF, 32'h0, 32'hc1, 1'b1, 1'b1);
        apply(32'hd0, pack(8'hf0, 8'hff, 8'hff, 8'hff, 8'hff, 8'hff));
        expect_all("R10 class F", 4'hF, 4'h0, 3'd1, 4'hF, 4'hF, 32'h0, 32'hd1, 1'b0, 1'b1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        pc = '0;
        fb = '0;
        t_idle();
        t_load_imm();
        t_mem_moves();
        t_branches();
        t_two_byte();
        t_one_byte();
        t_wrap();
        t_invalid();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule